// File: doc/BRIEF.md
# Single-Clock FIFO with Read Rewind

This block is a first-in first-out buffer of 36-bit words, with a depth of 512 or 1024 words set by a parameter. A write enable stores a word and a read enable fetches one. A full flag, an empty flag and two threshold flags report how many words are held. The threshold offsets are eight after reset, and software can reload them at any time through a load strobe.

A low level on the rewind strobe returns the read pointer to physical location zero. The write pointer keeps its value, so the region from location zero up to the write pointer can be read a second time. The occupancy is then set to the distance between the two pointers, and every flag follows from it.

The rewind gives the original data back only while the write pointer has never passed the last location. A sticky wrap indicator tells the user when that guarantee has been lost.

Top module: `fifo_rt`

## Requirements
- R1: After reset, `empty` and `almost_empty` are 1, `full`, `almost_full` and `wrapped` are 0, and `rd_data` is 0.
- R2: Words are read back in the order they were written. `rd_data` takes the new word at the same clock edge that samples an accepted `rd_en`, and otherwise holds its value.
- R3: A write while `full` is 1 is dropped. The occupancy and the stored words stay unchanged, and the word that is read next is the oldest stored word.
- R4: A read while `empty` is 1 is dropped. `rd_data` and the occupancy stay unchanged.
- R5: In a clock cycle where `rtx_n` is 0, the read pointer moves to location 0 and the write pointer does not move. Later reads return the words from location 0 onward, and later writes land after the last word written.
- R6: After a rewind, the occupancy equals the write pointer. This is the number of words written since reset as long as no wrap has occurred. If the wrap flag is set and the write pointer is 0, the occupancy equals DEPTH.
- R7: In a cycle where `rtx_n` is 0, `wr_en` and `rd_en` have no effect. No word is stored and `rd_data` holds its value.
- R8: `almost_empty` is 1 exactly when occupancy <= the empty offset. `almost_full` is 1 exactly when occupancy >= DEPTH minus the full offset. Both offsets are 8 after reset.
- R9: When `ofs_load` is 1 at a clock edge, `ofs_full` and `ofs_empty` become the new offsets. The flags use them from the next cycle on.
- R10: `wrapped` rises after a write is accepted at location DEPTH-1. It stays at 1 until reset.
- R11: `full` is 1 exactly when occupancy equals DEPTH, and `empty` is 1 exactly when occupancy is 0. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Last word read |
| rtx_n | input | 1 | Rewind strobe, active low |
| ofs_load | input | 1 | Load the threshold offsets |
| ofs_full | input | log2(DEPTH) | New almost-full offset |
| ofs_empty | input | log2(DEPTH) | New almost-empty offset |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| almost_full | output | 1 | Occupancy at or above the full threshold |
| almost_empty | output | 1 | Occupancy at or below the empty threshold |
| wrapped | output | 1 | Write pointer has passed the last location since reset |

## Verification
The assertions assume that every input is at a known level from the first clock edge after reset. They also assume that the rewind strobe is simply a level sampled at each edge, with no pulse-width rule. The properties on blocked accesses hold whatever the enables do. The property on the rewind cycle assumes only that `rtx_n` is sampled low at that edge.

The stimulus drives every input at the falling edge, so every value is settled well before the sampling edge. Offsets are loaded only with values below DEPTH, which the port width already enforces. Rewinds are mixed into the random traffic, both before and after a wrap, with the bench model applying the same pointer-distance rule.

// File: rtl/fifo_rt_pkg.sv
// Shared constants and types for the rewindable FIFO.
// Assumes the word width is fixed at 36 bits for the whole block.
package fifo_rt_pkg;
    parameter int WORD_W  = 36;
    parameter int DEF_OFS = 8;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fifo_rt_store.sv
// Word storage: one write port and one registered read port.
// Assumes the controller never reads and writes the same address in one cycle
// while that address holds live data.
module fifo_rt_store
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_word,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_word
);
    word_t cells [DEPTH];

    // Store an accepted word (no reset on the array).
    always_ff @(posedge clk) begin
        if (wr_fire)
            cells[wr_addr] <= wr_word;
    end

    // Present the addressed word on an accepted read, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_word <= '0;
        else if (rd_fire)
            rd_word <= cells[rd_addr];
    end
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Pointer and occupancy control with read rewind.
// Assumes rew is sampled as a level; when rew is high, both enables are ignored.
module fifo_rt_ctrl #(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              rew,
    output logic              wr_fire,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  occ,
    output logic              wrapped
);
    localparam logic [CNT_W-1:0]  OCC_MAX  = CNT_W'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_LOC = ADDR_W'(DEPTH - 1);

    logic [CNT_W-1:0] rew_occ;

    // Accept an access only when not rewinding and the boundary allows it.
    always_comb begin
        wr_fire = wr_req && !rew && (occ != OCC_MAX);
        rd_fire = rd_req && !rew && (occ != '0);
    end

    // Occupancy after a rewind: the distance from location zero to the write pointer.
    always_comb begin
        if (wrapped && (wr_ptr == '0))
            rew_occ = OCC_MAX;
        else
            rew_occ = {1'b0, wr_ptr};
    end

    // Advance the write pointer and record the first pass over the last location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (wr_fire) begin
            wr_ptr <= (wr_ptr == LAST_LOC) ? '0 : wr_ptr + 1'b1;
            if (wr_ptr == LAST_LOC)
                wrapped <= 1'b1;
        end
    end

    // Advance the read pointer, or send it back to location zero on a rewind.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (rew)
            rd_ptr <= '0;
        else if (rd_fire)
            rd_ptr <= (rd_ptr == LAST_LOC) ? '0 : rd_ptr + 1'b1;
    end

    // Track the number of held words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else if (rew)
            occ <= rew_occ;
        else if (wr_fire && !rd_fire)
            occ <= occ + 1'b1;
        else if (rd_fire && !wr_fire)
            occ <= occ - 1'b1;
    end
endmodule

// File: rtl/fifo_rt_flags.sv
// Threshold offset registers and status flag decode from the occupancy.
// Assumes the offsets are below DEPTH, which their width guarantees.
module fifo_rt_flags
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] new_full_ofs,
    input  logic [ADDR_W-1:0] new_empty_ofs,
    input  logic [CNT_W-1:0]  occ,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty
);
    localparam logic [CNT_W-1:0] OCC_MAX = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] full_ofs;
    logic [ADDR_W-1:0] empty_ofs;

    // Hold the threshold offsets; they start at the default value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_ofs  <= ADDR_W'(DEF_OFS);
            empty_ofs <= ADDR_W'(DEF_OFS);
        end else if (load) begin
            full_ofs  <= new_full_ofs;
            empty_ofs <= new_empty_ofs;
        end
    end

    // Decode the four flags from the occupancy.
    always_comb begin
        full         = (occ == OCC_MAX);
        empty        = (occ == '0);
        almost_full  = (occ >= (OCC_MAX - {1'b0, full_ofs}));
        almost_empty = (occ <= {1'b0, empty_ofs});
    end
endmodule

// File: rtl/fifo_rt.sv
// Top of the single-clock FIFO with an active-low read rewind.
// Assumes one clock and a synchronous active-low reset. The rewind reproduces
// the written data only while the wrapped output is still low.
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH  = 512,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [35:0]       wr_data,
    input  logic              rd_en,
    output logic [35:0]       rd_data,
    input  logic              rtx_n,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ofs_full,
    input  logic [ADDR_W-1:0] ofs_empty,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              wrapped
);
    logic              wr_fire;
    logic              rd_fire;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  occ;
    logic              rew;

    // Convert the active-low strobe to an internal active-high level.
    always_comb rew = !rtx_n;

    fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_en),
        .rd_req  (rd_en),
        .rew     (rew),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .occ     (occ),
        .wrapped (wrapped)
    );

    fifo_rt_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_addr (wr_ptr),
        .wr_word (wr_data),
        .rd_fire (rd_fire),
        .rd_addr (rd_ptr),
        .rd_word (rd_data)
    );

    fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (ofs_load),
        .new_full_ofs  (ofs_full),
        .new_empty_ofs (ofs_empty),
        .occ           (occ),
        .full          (full),
        .empty         (empty),
        .almost_full   (almost_full),
        .almost_empty  (almost_empty)
    );
endmodule

// File: rtl/fifo_rt_chk.sv
// Property checker for fifo_rt, attached to every instance through bind.
// Assumes all inputs are known from the first edge after reset.
module fifo_rt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic        rtx_n,
    input logic [35:0] rd_data,
    input logic        full,
    input logic        empty,
    input logic        almost_empty,
    input logic        wrapped
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (empty && almost_empty && !full && !wrapped && rd_data == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && rtx_n) |=> full);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && rtx_n) |=> (empty && $stable(rd_data)));

    p_rewind_holds_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rtx_n |=> $stable(rd_data));

    p_empty_implies_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);

    p_wrap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);

    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind fifo_rt fifo_rt_chk u_fifo_rt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rtx_n        (rtx_n),
    .rd_data      (rd_data),
    .full         (full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .wrapped      (wrapped)
);

// File: tb/fifo_rt_bench.sv
// Self-checking bench: directed corner cases and seeded random traffic,
// compared against a reference model kept in bench variables.
module fifo_rt_bench;
    localparam int DEPTH  = 512;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [35:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [35:0]       rd_data;
    logic              rtx_n = 1'b1;
    logic              ofs_load = 1'b0;
    logic [ADDR_W-1:0] ofs_full = '0;
    logic [ADDR_W-1:0] ofs_empty = '0;
    logic              full, empty, almost_full, almost_empty, wrapped;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [35:0] m_mem [DEPTH];
    int          m_wp, m_rp, m_cnt, m_af, m_ae;
    bit          m_wrap;
    logic [35:0] m_rd;

    always #2 clk = ~clk;

    fifo_rt #(.DEPTH(DEPTH)) u_fifo_rt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rtx_n(rtx_n),
        .ofs_load(ofs_load), .ofs_full(ofs_full), .ofs_empty(ofs_empty),
        .full(full), .empty(empty), .almost_full(almost_full),
        .almost_empty(almost_empty), .wrapped(wrapped)
    );

    function automatic bit exp_af();
        return m_cnt >= DEPTH - m_af;
    endfunction
    function automatic bit exp_ae();
        return m_cnt <= m_ae;
    endfunction
    function automatic int rewind_occ();
        return (m_wrap && m_wp == 0) ? DEPTH : m_wp;
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_wp = 0; m_rp = 0; m_cnt = 0; m_wrap = 0; m_af = 8; m_ae = 8; m_rd = '0;
    endtask

    // Update the model with the inputs sampled at one clock edge.
    task automatic model_step();
        bit wok, rok;
        if (!rtx_n) begin
            m_rp = 0;
            m_cnt = rewind_occ();
        end else begin
            wok = wr_en && (m_cnt < DEPTH);
            rok = rd_en && (m_cnt > 0);
            if (rok) begin
                m_rd = m_mem[m_rp];
                m_rp = (m_rp + 1) % DEPTH;
            end
            if (wok) begin
                m_mem[m_wp] = wr_data;
                if (m_wp == DEPTH - 1) m_wrap = 1;
                m_wp = (m_wp + 1) % DEPTH;
            end
            m_cnt = m_cnt + int'(wok) - int'(rok);
        end
        if (ofs_load) begin
            m_af = int'(ofs_full);
            m_ae = int'(ofs_empty);
        end
    endtask

    task automatic check_all();
        chk("R2 rd_data", rd_data, m_rd);
        chk("R11 full", 36'(full), 36'(m_cnt == DEPTH));
        chk("R11 empty", 36'(empty), 36'(m_cnt == 0));
        chk("R8 almost_full", 36'(almost_full), 36'(exp_af()));
        chk("R8 almost_empty", 36'(almost_empty), 36'(exp_ae()));
        chk("R10 wrapped", 36'(wrapped), 36'(m_wrap));
    endtask

    // One clock: drive at the falling edge, step the model, check at the next falling edge.
    task automatic cyc(input bit we, input logic [35:0] wd, input bit re, input bit rt);
        wr_en = we; wr_data = wd; rd_en = re; rtx_n = rt;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rtx_n = 1'b1; ofs_load = 1'b0;
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 empty", 36'(empty), 36'd1);
        chk("R1 almost_empty", 36'(almost_empty), 36'd1);
        chk("R1 full", 36'(full), 36'd0);
        chk("R1 almost_full", 36'(almost_full), 36'd0);
        chk("R1 wrapped", 36'(wrapped), 36'd0);
        chk("R1 rd_data", rd_data, 36'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [35:0] held;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        do_reset();

        // R2: short burst of writes then reads
        for (int i = 0; i < 5; i++) cyc(1, 36'h1_0000_0000 + 36'(i), 0, 1);
        for (int i = 0; i < 5; i++) begin
            cyc(0, '0, 1, 1);
            chk("R2 order", rd_data, 36'h1_0000_0000 + 36'(i));
        end

        // R4: read while empty is dropped
        held = rd_data;
        cyc(0, '0, 1, 1);
        chk("R4 rd_data held", rd_data, held);
        chk("R4 still empty", 36'(empty), 36'd1);

        // R5, R6: rewind after 5 writes and 5 reads
        cyc(0, '0, 0, 0);
        chk("R6 occupancy after rewind not empty", 36'(empty), 36'd0);
        cyc(0, '0, 1, 1);
        chk("R5 first word again", rd_data, 36'h1_0000_0000);
        cyc(1, 36'hA_BCDE_0005, 0, 1);
        for (int i = 1; i < 5; i++) begin
            cyc(0, '0, 1, 1);
            chk("R5 replay", rd_data, 36'h1_0000_0000 + 36'(i));
        end
        cyc(0, '0, 1, 1);
        chk("R5 write pointer kept", rd_data, 36'hA_BCDE_0005);

        // R7: enables ignored during rewind
        held = rd_data;
        cyc(1, 36'hD_EAD0_0000, 1, 0);
        chk("R7 rd_data held", rd_data, held);
        chk("R6 occupancy equals write pointer", 36'(almost_empty), 36'd1);

        // R9: load new offsets
        ofs_load = 1'b1; ofs_full = ADDR_W'(3); ofs_empty = ADDR_W'(2);
        cyc(0, '0, 0, 1);
        chk("R9 almost_empty with ofs 2", 36'(almost_empty), 36'(m_cnt <= 2));

        // R3: fill to full, then a dropped write
        while (m_cnt < DEPTH) cyc(1, 36'($urandom) ^ {4'h0, 32'($urandom)}, 0, 1);
        chk("R11 full reached", 36'(full), 36'd1);
        cyc(1, 36'hF_FFFF_FFFF, 0, 1);
        chk("R3 still full", 36'(full), 36'd1);
        cyc(0, '0, 0, 0);
        cyc(0, '0, 1, 1);
        chk("R3 oldest word kept", rd_data, m_mem[0]);
        chk("R10 wrapped after last location", 36'(wrapped), 36'd1);

        // Random traffic with occasional rewinds and offset loads
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            bit we, re, rt;
            we = ($urandom % 100) < 55;
            re = ($urandom % 100) < 50;
            rt = ($urandom % 100) >= 2;
            if (($urandom % 200) == 0) begin
                ofs_load = 1'b1;
                ofs_full = ADDR_W'($urandom % 20);
                ofs_empty = ADDR_W'($urandom % 20);
            end
            cyc(we, {4'($urandom), 32'($urandom)}, re, rt);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule